// File: doc/BRIEF.md
# Inter-Processor Mailbox

The mailbox lets several processors on one chip hand 32-bit words to each other through a bank of small hardware queues. Every queue and register is reached through one word-wide register port. A write to a queue's message word adds an entry at the tail. A read of the same word removes the entry at the head and returns it. Each queue also has two read-only words: one tells whether the queue is full, and the other tells how many entries it holds.

Four users share the block, and each user has its own interrupt line. Each queue produces two events. A "message arrived" event fires on every accepted push. A "space freed" event fires when a pop takes a full queue below full. Every event is latched into all four users' status words. Each user unmasks the events it wants in its own enable word and clears events by writing ones to its status word. A user's interrupt line is high when any of its events is both latched and unmasked. A fixed identification word and a two-bit idle-mode configuration word complete the map.

The register read port is registered. Read data is valid in the cycle after the read is presented. A pop takes effect on the same clock edge that captures the data.

Top module: `ipc_mailbox`

## Requirements
- R1: There are six queues, each 4 entries of 32 bits. Queue n's message word is at byte offset 0x40+4n. A write appends the word, and a read returns the entries oldest first, one entry per read.
- R2: A write to a queue that already holds 4 entries is dropped. A read of an empty queue returns 0, and the entry count stays unchanged.
- R3: The word at 0x80+4n reads 1 while queue n holds 4 entries, and 0 otherwise.
- R4: The word at 0xC0+4n reads the number of entries queue n holds (0 to 4).
- R5: User u's status word is at 0x100+8u. Every accepted push into queue n sets bit 2n in the status word of all four users.
- R6: A pop that leaves queue n with 3 entries after it held 4 sets bit 2n+1 in all four users' status words.
- R7: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged. Bits 12 to 31 always read 0.
- R8: User u's enable word is at 0x104+8u. Bits 0 to 11 are plain read/write, and bits 12 to 31 read 0.
- R9: user_irq[u] is high in the cycle after some bit is set in both user u's status word and user u's enable word, and low in the cycle after no such bit exists.
- R10: Offset 0x00 reads the identification constant 0x0001_0002. Offset 0x10 keeps bits 0 and 4 as read/write and reads 0 in every other bit. Every other offset below 0x40 reads 0.
- R11: After reset, every queue is empty, all status, enable and configuration bits are 0, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| user_irq | output | 4 | Per-user interrupt lines, registered |

## Verification
Corrupted queue pointers or counts appear at the ports on the next read. That read can be a pop that returns the wrong word or a non-zero value from an empty queue, or a count or full word that disagrees with the number of words pushed. A stuck or wrongly placed event bit shows up in a status read within one access. It also shows up on the interrupt line one cycle later, because the bench compares user_irq after every access. Directed cases cover the overflow boundary, a pop from a full queue and a read of an empty queue. The random sequences then exercise interleavings across all queues and users.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int MBOX_AW = 9;

  typedef enum logic [2:0] {
    RG_MISC,
    RG_MSG,
    RG_FULL,
    RG_CNT,
    RG_USR
  } region_e;

  // Bit 8 selects the per-user area; bits 7:6 select the per-queue area.
  function automatic region_e decode_region(input logic [MBOX_AW-1:0] a);
    if (a[8]) return RG_USR;
    case (a[7:6])
      2'd1:    return RG_MSG;
      2'd2:    return RG_FULL;
      2'd3:    return RG_CNT;
      default: return RG_MISC;
    endcase
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          pushed,
  output logic          freed
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushed = push && !full;
  assign freed  = pop && full;
  assign head   = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushed) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pushed) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({pushed, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));
  a_r2_empty_pop_inert: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> $stable(count));
  a_r6_pop_leaves_full: assert property (@(posedge clk) disable iff (rst)
    (pop && full && !push) |=> !full);
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int EVW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] set_ev,
  input  logic           clr_wr,
  input  logic           en_wr,
  input  logic [EVW-1:0] wdata,
  output logic [EVW-1:0] stat,
  output logic [EVW-1:0] en,
  output logic           irq
);
  logic [EVW-1:0] clr_mask;
  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr_mask) | set_ev;
      if (en_wr) en <= wdata;
      irq  <= |(stat & en);
    end
  end

  a_r5_event_latched: assert property (@(posedge clk) disable iff (rst)
    (set_ev != '0) |=> ((stat & $past(set_ev)) == $past(set_ev)));
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && set_ev == '0) |=> ((stat & $past(wdata)) == '0));
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int          NQ     = 6,
  parameter int          DEPTH  = 4,
  parameter int          DW     = 32,
  parameter int          NU     = 4,
  parameter logic [31:0] REV_ID = 32'h0001_0002
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [MBOX_AW-1:0] bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NU-1:0]      user_irq
);
  localparam int EVW = 2 * NQ;
  localparam int CW  = $clog2(DEPTH + 1);

  region_e    region;
  logic [3:0] qidx;
  logic [4:0] uidx;
  logic       rd_req, wr_req;
  logic [1:0] cfg;
  logic [DW-1:0] rd_mux;
  logic       unused_addr;

  assign region      = decode_region(bus_addr);
  assign qidx        = bus_addr[5:2];
  assign uidx        = bus_addr[7:3];
  assign rd_req      = bus_sel && !bus_wr;
  assign wr_req      = bus_sel && bus_wr;
  assign unused_addr = ^bus_addr[1:0];

  logic [DW-1:0] q_head  [NQ];
  logic [CW-1:0] q_count [NQ];
  logic [NQ-1:0] q_full, q_empty, q_pushed, q_freed;
  logic [EVW-1:0] ev_set;
  logic [EVW-1:0] u_stat [NU];
  logic [EVW-1:0] u_en   [NU];

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic hit;
    assign hit = (region == RG_MSG) && (qidx == 4'(q));
    mbox_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .push   (wr_req && hit),
      .pop    (rd_req && hit),
      .wdata  (bus_wdata),
      .head   (q_head[q]),
      .count  (q_count[q]),
      .full   (q_full[q]),
      .empty  (q_empty[q]),
      .pushed (q_pushed[q]),
      .freed  (q_freed[q])
    );
    assign ev_set[2*q]   = q_pushed[q];
    assign ev_set[2*q+1] = q_freed[q];
  end

  for (genvar u = 0; u < NU; u++) begin : g_user
    logic hit;
    assign hit = wr_req && (region == RG_USR) && (uidx == 5'(u));
    mbox_user_irq #(.EVW(EVW)) u_irq (
      .clk    (clk),
      .rst    (rst),
      .set_ev (ev_set),
      .clr_wr (hit && !bus_addr[2]),
      .en_wr  (hit && bus_addr[2]),
      .wdata  (bus_wdata[EVW-1:0]),
      .stat   (u_stat[u]),
      .en     (u_en[u]),
      .irq    (user_irq[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (wr_req && region == RG_MISC && bus_addr[7:2] == 6'd4)
      cfg <= {bus_wdata[4], bus_wdata[0]};
  end

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_MISC: begin
        if (bus_addr[7:2] == 6'd0) rd_mux = REV_ID;
        else if (bus_addr[7:2] == 6'd4) begin
          rd_mux[0] = cfg[0];
          rd_mux[4] = cfg[1];
        end
      end
      RG_MSG:
        for (int i = 0; i < NQ; i++)
          if (qidx == 4'(i) && !q_empty[i]) rd_mux = q_head[i];
      RG_FULL:
        for (int i = 0; i < NQ; i++)
          if (qidx == 4'(i)) rd_mux = {{(DW-1){1'b0}}, q_full[i]};
      RG_CNT:
        for (int i = 0; i < NQ; i++)
          if (qidx == 4'(i)) rd_mux = {{(DW-CW){1'b0}}, q_count[i]};
      RG_USR:
        for (int i = 0; i < NU; i++)
          if (uidx == 5'(i))
            rd_mux = {{(DW-EVW){1'b0}}, bus_addr[2] ? u_en[i] : u_stat[i]};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  a_r10_cfg_reserved: assert property (@(posedge clk) disable iff (rst)
    (rd_req && region == RG_MISC && bus_addr[7:2] == 6'd4) |=>
      ((bus_rdata & ~32'h11) == '0));
  a_r11_irq_low_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (user_irq == '0));
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 6, NU = 4, DEPTH = 4;

  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  user_irq;

  ipc_mailbox uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .user_irq(user_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [31:0] mq [NQ][DEPTH];
  int          mcnt [NQ];
  logic [11:0] mstat [NU];
  logic [11:0] men [NU];
  logic [31:0] mcfg;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [8:0] a);
    int q = a[5:2];
    int u = a[7:3];
    if (a[8]) return (u < NU) ? {20'h0, a[2] ? men[u] : mstat[u]} : 32'h0;
    case (a[7:6])
      2'd1: return (q < NQ && mcnt[q] > 0) ? mq[q][0] : 32'h0;
      2'd2: return (q < NQ && mcnt[q] == DEPTH) ? 32'h1 : 32'h0;
      2'd3: return (q < NQ) ? 32'(mcnt[q]) : 32'h0;
      default: begin
        if (a[7:2] == 6'd0) return 32'h0001_0002;
        if (a[7:2] == 6'd4) return mcfg;
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    if (a[8]) return a[2] ? "R8" : "R5";
    case (a[7:6])
      2'd1: return "R1";
      2'd2: return "R3";
      2'd3: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic model_apply(input bit wr, input logic [8:0] a, input logic [31:0] d);
    int q = a[5:2];
    int u = a[7:3];
    if (a[8]) begin
      if (wr && u < NU) begin
        if (a[2]) men[u] = d[11:0];
        else mstat[u] = mstat[u] & ~d[11:0];
      end
    end else if (a[7:6] == 2'd1 && q < NQ) begin
      if (wr) begin
        if (mcnt[q] < DEPTH) begin
          mq[q][mcnt[q]] = d;
          mcnt[q]++;
          for (int k = 0; k < NU; k++) mstat[k][2*q] = 1'b1;
        end
      end else if (mcnt[q] > 0) begin
        if (mcnt[q] == DEPTH)
          for (int k = 0; k < NU; k++) mstat[k][2*q+1] = 1'b1;
        for (int k = 0; k < DEPTH-1; k++) mq[q][k] = mq[q][k+1];
        mcnt[q]--;
      end
    end else if (a[7:6] == 2'd0 && a[7:2] == 6'd4 && wr) begin
      mcfg = d & 32'h11;
    end
  endtask

  task automatic bus_op(input bit wr, input logic [8:0] a, input logic [31:0] d,
                        input string tag);
    logic [3:0]  exp_irq;
    logic [31:0] exp_rd;
    for (int k = 0; k < NU; k++) exp_irq[k] = |(mstat[k] & men[k]);
    exp_rd = model_read(a);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 0;
    model_apply(wr, a, d);
    check("R9 irq", {28'h0, user_irq}, {28'h0, exp_irq});
    if (!wr) check(tag, bus_rdata, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int q = 0; q < NQ; q++) mcnt[q] = 0;
    for (int u = 0; u < NU; u++) begin mstat[u] = '0; men[u] = '0; end
    mcfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R11: reset state
    check("R11 irq", {28'h0, user_irq}, 32'h0);
    bus_op(0, 9'h000, 0, "R11 R10 revision");
    bus_op(0, 9'h0C0, 0, "R11 count q0");
    bus_op(0, 9'h100, 0, "R11 status u0");
    bus_op(0, 9'h10C, 0, "R11 enable u1");
    bus_op(0, 9'h010, 0, "R11 cfg");

    // R1/R2/R3/R4: fill q0 past capacity
    for (int i = 0; i < 5; i++) bus_op(1, 9'h040, 32'hA000_0000 + i, "");
    bus_op(0, 9'h080, 0, "R3 full");
    bus_op(0, 9'h0C0, 0, "R2 R4 count capped");
    bus_op(0, 9'h118, 0, "R5 status u3");
    bus_op(0, 9'h040, 0, "R1 oldest first");
    bus_op(0, 9'h110, 0, "R6 freed bit");
    bus_op(0, 9'h080, 0, "R3 not full");
    // R2: empty read
    bus_op(0, 9'h054, 0, "R2 empty read");
    bus_op(0, 9'h0D4, 0, "R2 count unchanged");
    // R7: clear one bit, zeros keep others
    bus_op(1, 9'h100, 32'h0000_0002, "");
    bus_op(0, 9'h100, 0, "R7 w1c");
    bus_op(1, 9'h100, 32'h0, "");
    bus_op(0, 9'h100, 0, "R7 zero write");
    // R8/R9
    bus_op(1, 9'h10C, 32'hFFFF_FFFF, "");
    bus_op(0, 9'h10C, 0, "R8 enable");
    bus_op(0, 9'h000, 0, "R9 irq rises");
    bus_op(1, 9'h108, 32'hFFF, "");
    bus_op(0, 9'h000, 0, "R9 irq falls");
    // R10
    bus_op(1, 9'h010, 32'hFFFF_FFFF, "");
    bus_op(0, 9'h010, 0, "R10 cfg");
    bus_op(0, 9'h020, 0, "R10 unmapped");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int kind = $urandom % 10;
      int q = $urandom % NQ;
      int u = $urandom % NU;
      logic [31:0] d = $urandom;
      logic [8:0] a;
      bit wr;
      case (kind)
        0, 1, 2: begin a = 9'(9'h040 + 4*q); wr = 1; end
        3, 4:    begin a = 9'(9'h040 + 4*q); wr = 0; end
        5:       begin a = 9'(9'h080 + 4*q); wr = 0; end
        6:       begin a = 9'(9'h0C0 + 4*q); wr = 0; end
        7:       begin a = 9'(9'h100 + 8*u); wr = ($urandom % 4) == 0; end
        8:       begin a = 9'(9'h104 + 8*u); wr = $urandom % 2; end
        default: begin a = 9'(4 * ($urandom % 16)); wr = $urandom % 2; end
      endcase
      bus_op(wr, a, d, tag_of(a));
    end
    summary();
  end
endmodule